// File: doc/BRIEF.md
# Reconfigurable Add-Compare-Select Butterfly Array

This block holds the path metrics of a binary convolutional-code trellis and advances all of them by one trellis stage per update cycle. One add-compare-select butterfly unit exists for each butterfly of the largest supported code (constraint length `K_MAX`, `2^(K_MAX-2)` units). Smaller codes, from constraint length 3 upward, reuse the low-indexed part of the same array. A routing stage, driven by the configured constraint length, decides which unit output lands in which state register.

A run begins with a `start` pulse. The pulse captures the constraint length and the soft-output (turbo) flag and loads the starting metrics. Each later `step` cycle supplies four branch metrics per butterfly. The array then updates every live state, records per new state the decision bit that selects the surviving predecessor, and in turbo mode records the magnitude of the gap between the two competing candidates. Units not needed for the configured code have their inputs isolated and their results discarded. Their enable mask is exported so that clock-gating cells outside the block can stop them. Branch metric generation, decision storage and traceback sit outside this block.

Top module: `acs_array`

## Requirements
- R1: Butterfly j (j < 2^(K-2)) reads old states 2j and 2j+1 and writes new states j and j+2^(K-2). Its branch-metric field f (f = 0..3) sits at `bm_flat[(4j+f)*BMW +: BMW]`. The candidates for new state j are old(2j)+field0 and old(2j+1)+field1. The candidates for new state j+2^(K-2) are old(2j)+field2 and old(2j+1)+field3.
- R2: A `start` cycle sets state 0 to metric 0, every other state to 512 (2^(PMW-3)), and all decision bits and differences to 0. It captures `cfg_k` and `cfg_turbo`. It takes priority over a `step` in the same cycle, and it produces no `out_valid`.
- R3: Each live new state keeps the smaller of its two candidates. Metrics are stored modulo 2^PMW, and candidates are compared by the sign of their PMW-bit modulo difference.
- R4: A decision bit is 1 when the candidate from the odd old state (2j+1) is strictly smaller. On a tie it is 0.
- R5: In turbo mode, each live state's difference output is |candidate0 - candidate1|. In Viterbi mode (`cfg_turbo`=0) every difference output is 0.
- R6: States with index at or above 2^(K-1) keep their metric, decision bit and difference through every step.
- R7: `unit_active` bit j is 1 exactly when j < 2^(K-2).
- R8: A `cfg_k` below 3 is treated as 3, and one above `K_MAX` (7) as `K_MAX`.
- R9: Without `start` or `step`, no output changes. `out_valid` is high exactly in the cycle after a `step` cycle that had no `start`.
- R10: Changes on `cfg_k` or `cfg_turbo` after the `start` cycle have no effect until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load starting metrics and capture configuration |
| cfg_k | input | 4 | Constraint length, sampled on `start` |
| cfg_turbo | input | 1 | Soft-output mode, sampled on `start` |
| step | input | 1 | Advance one trellis stage |
| bm_flat | input | 4*NUM_UNITS*BMW | Four branch metrics per butterfly unit |
| pm_flat | output | NUM_STATES*PMW | Path metric of each state, state s at `[s*PMW +: PMW]` |
| dec_vec | output | NUM_STATES | Decision bit of each state from the last stage |
| diff_flat | output | NUM_STATES*PMW | Candidate gap of each state from the last stage |
| unit_active | output | NUM_UNITS | Enable mask of the butterfly units |
| out_valid | output | 1 | Stage results updated in the previous cycle |

## Verification
The bench sweeps every constraint length from 3 to 7, in both modes, and checks all 64 state slots after every stage against integer trellis arithmetic. A fault in the upper-half write routing would corrupt state j+2^(K-2) only for some K. Runs of a few hundred stages push the stored metrics past 4096, so an unsigned in place of a modulo comparison would pick the wrong survivor once wrapping begins. Tie patterns catch a decision bit that favours the odd path on equality. Idle gaps, out-of-range `cfg_k` values and configuration pins toggled mid-run catch states above 2^(K-1) being written, a missing clamp, and configuration that is not latched.

// File: rtl/acs_pkg.sv
package acs_pkg;

  // Limit a requested constraint length to the supported range.
  function automatic logic [3:0] clamp_k(input logic [3:0] k_req, input int unsigned k_max);
    logic [3:0] k_out;
    if (k_req < 4'd3)               k_out = 4'd3;
    else if (32'(k_req) > k_max)    k_out = 4'(k_max);
    else                            k_out = k_req;
    return k_out;
  endfunction

endpackage

// File: rtl/acs_node.sv
module acs_node #(
  parameter int PMW = 12,
  parameter int BMW = 6
) (
  input  logic           en,
  input  logic           turbo,
  input  logic [PMW-1:0] pm_a,
  input  logic [PMW-1:0] pm_b,
  input  logic [BMW-1:0] bm_a,
  input  logic [BMW-1:0] bm_b,
  output logic [PMW-1:0] surv,
  output logic           dec,
  output logic [PMW-1:0] diff
);

  logic [PMW-1:0] cand_a;
  logic [PMW-1:0] cand_b;
  logic [PMW-1:0] delta;
  logic           b_wins;

  always_comb begin
    cand_a = '0;
    cand_b = '0;
    delta  = '0;
    b_wins = 1'b0;
    surv   = '0;
    dec    = 1'b0;
    diff   = '0;
    if (en) begin
      cand_a = pm_a + PMW'(bm_a);
      cand_b = pm_b + PMW'(bm_b);
      delta  = cand_a - cand_b;
      // positive modulo gap means the odd-side candidate is smaller
      b_wins = !delta[PMW-1] && (delta != '0);
      surv   = b_wins ? cand_b : cand_a;
      dec    = b_wins;
      if (turbo) diff = delta[PMW-1] ? (~delta + 1'b1) : delta;
    end
  end

endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly #(
  parameter int PMW = 12,
  parameter int BMW = 6
) (
  input  logic                  en,
  input  logic                  turbo,
  input  logic [PMW-1:0]        pm_even,
  input  logic [PMW-1:0]        pm_odd,
  input  logic [4*BMW-1:0]      bm_quad,
  output logic [1:0][PMW-1:0]   surv,
  output logic [1:0]            dec,
  output logic [1:0][PMW-1:0]   diff
);

  // half 0 feeds new state j, half 1 feeds new state j + 2^(K-2)
  for (genvar g = 0; g < 2; g++) begin : g_half
    acs_node #(.PMW(PMW), .BMW(BMW)) node_i (
      .en    (en),
      .turbo (turbo),
      .pm_a  (pm_even),
      .pm_b  (pm_odd),
      .bm_a  (bm_quad[(2*g)*BMW +: BMW]),
      .bm_b  (bm_quad[(2*g+1)*BMW +: BMW]),
      .surv  (surv[g]),
      .dec   (dec[g]),
      .diff  (diff[g])
    );
  end

endmodule

// File: rtl/acs_route.sv
module acs_route #(
  parameter int K_MAX = 7,
  parameter int PMW   = 12,
  localparam int NUM_UNITS  = 1 << (K_MAX - 2),
  localparam int NUM_STATES = 1 << (K_MAX - 1),
  localparam int UW         = $clog2(NUM_UNITS)
) (
  input  logic [3:0]                            k_val,
  input  logic [NUM_UNITS-1:0][1:0][PMW-1:0]    unit_surv,
  input  logic [NUM_UNITS-1:0][1:0]             unit_dec,
  input  logic [NUM_UNITS-1:0][1:0][PMW-1:0]    unit_diff,
  output logic [NUM_STATES-1:0][PMW-1:0]        nxt_pm,
  output logic [NUM_STATES-1:0]                 nxt_dec,
  output logic [NUM_STATES-1:0][PMW-1:0]        nxt_diff,
  output logic [NUM_STATES-1:0]                 st_active,
  output logic [NUM_UNITS-1:0]                  unit_active
);

  // unit enable decode
  for (genvar j = 0; j < NUM_UNITS; j++) begin : g_unit
    always_comb begin
      unit_active[j] = 1'b0;
      for (int k = 3; k <= K_MAX; k++) begin
        if (k_val == 4'(k) && j < (1 << (k - 2))) unit_active[j] = 1'b1;
      end
    end
  end

  // write-back mux bank: one selector per state
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    logic [UW-1:0] sel_u;
    logic          sel_h;
    logic          act;

    always_comb begin
      sel_u = '0;
      sel_h = 1'b0;
      act   = 1'b0;
      for (int k = 3; k <= K_MAX; k++) begin
        if (k_val == 4'(k)) begin
          if (s < (1 << (k - 2))) begin
            act   = 1'b1;
            sel_u = UW'(s);
          end else if (s < (1 << (k - 1))) begin
            act   = 1'b1;
            sel_h = 1'b1;
            sel_u = UW'(s - (1 << (k - 2)));
          end
        end
      end
    end

    always_comb begin
      st_active[s] = act;
      nxt_pm[s]    = unit_surv[sel_u][sel_h];
      nxt_dec[s]   = unit_dec[sel_u][sel_h];
      nxt_diff[s]  = unit_diff[sel_u][sel_h];
    end
  end

endmodule

// File: rtl/acs_array.sv
module acs_array #(
  parameter int K_MAX = 7,
  parameter int PMW   = 12,
  parameter int BMW   = 6,
  localparam int NUM_UNITS  = 1 << (K_MAX - 2),
  localparam int NUM_STATES = 1 << (K_MAX - 1),
  localparam logic [PMW-1:0] PM_INIT = PMW'(1) << (PMW - 3)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [3:0]                  cfg_k,
  input  logic                        cfg_turbo,
  input  logic                        step,
  input  logic [4*NUM_UNITS*BMW-1:0]  bm_flat,
  output logic [NUM_STATES*PMW-1:0]   pm_flat,
  output logic [NUM_STATES-1:0]       dec_vec,
  output logic [NUM_STATES*PMW-1:0]   diff_flat,
  output logic [NUM_UNITS-1:0]        unit_active,
  output logic                        out_valid
);

  import acs_pkg::*;

  logic [3:0]                           k_q, k_d;
  logic                                 turbo_q, turbo_d;
  logic [NUM_STATES-1:0][PMW-1:0]       pm_q, pm_d;
  logic [NUM_STATES-1:0]                dec_q, dec_d;
  logic [NUM_STATES-1:0][PMW-1:0]       diff_q, diff_d;
  logic                                 ov_q, ov_d;
  logic                                 upd;

  logic [NUM_UNITS-1:0][1:0][PMW-1:0]   unit_surv;
  logic [NUM_UNITS-1:0][1:0]            unit_dec;
  logic [NUM_UNITS-1:0][1:0][PMW-1:0]   unit_diff;
  logic [NUM_STATES-1:0][PMW-1:0]       nxt_pm;
  logic [NUM_STATES-1:0]                nxt_dec;
  logic [NUM_STATES-1:0][PMW-1:0]       nxt_diff;
  logic [NUM_STATES-1:0]                st_active;

  // butterfly array: unit j always reads old states 2j and 2j+1
  for (genvar j = 0; j < NUM_UNITS; j++) begin : g_bfly
    acs_butterfly #(.PMW(PMW), .BMW(BMW)) bfly_i (
      .en      (unit_active[j]),
      .turbo   (turbo_q),
      .pm_even (pm_q[2*j]),
      .pm_odd  (pm_q[2*j+1]),
      .bm_quad (bm_flat[j*4*BMW +: 4*BMW]),
      .surv    (unit_surv[j]),
      .dec     (unit_dec[j]),
      .diff    (unit_diff[j])
    );
  end

  acs_route #(.K_MAX(K_MAX), .PMW(PMW)) route_i (
    .k_val       (k_q),
    .unit_surv   (unit_surv),
    .unit_dec    (unit_dec),
    .unit_diff   (unit_diff),
    .nxt_pm      (nxt_pm),
    .nxt_dec     (nxt_dec),
    .nxt_diff    (nxt_diff),
    .st_active   (st_active),
    .unit_active (unit_active)
  );

  // next-state logic
  always_comb begin
    upd     = start | step;
    k_d     = k_q;
    turbo_d = turbo_q;
    pm_d    = pm_q;
    dec_d   = dec_q;
    diff_d  = diff_q;
    ov_d    = step & ~start;
    if (start) begin
      k_d     = clamp_k(cfg_k, K_MAX);
      turbo_d = cfg_turbo;
      for (int s = 0; s < NUM_STATES; s++) pm_d[s] = (s == 0) ? '0 : PM_INIT;
      dec_d   = '0;
      diff_d  = '0;
    end else if (step) begin
      for (int s = 0; s < NUM_STATES; s++) begin
        if (st_active[s]) begin
          pm_d[s]   = nxt_pm[s];
          dec_d[s]  = nxt_dec[s];
          diff_d[s] = nxt_diff[s];
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= 4'(K_MAX);
      turbo_q <= 1'b0;
      for (int s = 0; s < NUM_STATES; s++) pm_q[s] <= (s == 0) ? '0 : PM_INIT;
      dec_q   <= '0;
      diff_q  <= '0;
      ov_q    <= 1'b0;
    end else begin
      ov_q <= ov_d;
      if (start) begin
        k_q     <= k_d;
        turbo_q <= turbo_d;
      end
      if (upd) begin
        pm_q   <= pm_d;
        dec_q  <= dec_d;
        diff_q <= diff_d;
      end
    end
  end

  assign pm_flat   = pm_q;
  assign dec_vec   = dec_q;
  assign diff_flat = diff_q;
  assign out_valid = ov_q;

  // assertions
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> ($stable(pm_q) && $stable(dec_q) && $stable(diff_q))); // R9

  AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pm_q[0] == '0 && dec_q == '0 && diff_q == '0 && !out_valid)); // R2

  AST_VITERBI_NO_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    !turbo_q |-> (diff_q == '0)); // R5

  AST_UNIT_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_active[0] && ((unit_active & (unit_active + NUM_UNITS'(1))) == '0))); // R7

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_chk
    AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && !st_active[s]) |=> $stable(pm_q[s])); // R6

    AST_TIE_DEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (turbo_q && diff_q[s] == '0) |-> !dec_q[s]); // R4
  end

endmodule

// File: tb/acs_array_tb_top.sv
module acs_array_tb_top;

  localparam int K_MAX = 7;
  localparam int PMW   = 12;
  localparam int BMW   = 6;
  localparam int NU    = 1 << (K_MAX - 2);
  localparam int NS    = 1 << (K_MAX - 1);
  localparam longint MODV = 64'd1 << PMW;

  logic                   clk;
  logic                   rst_n;
  logic                   start;
  logic [3:0]             cfg_k;
  logic                   cfg_turbo;
  logic                   step;
  logic [4*NU*BMW-1:0]    bm_flat;
  logic [NS*PMW-1:0]      pm_flat;
  logic [NS-1:0]          dec_vec;
  logic [NS*PMW-1:0]      diff_flat;
  logic [NU-1:0]          unit_active;
  logic                   out_valid;

  acs_array #(.K_MAX(K_MAX), .PMW(PMW), .BMW(BMW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k), .cfg_turbo(cfg_turbo),
    .step(step), .bm_flat(bm_flat), .pm_flat(pm_flat), .dec_vec(dec_vec),
    .diff_flat(diff_flat), .unit_active(unit_active), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int     n_chk;
  int     n_fail;
  longint ref_pm   [NS];
  int     ref_dec  [NS];
  longint ref_diff [NS];
  int     bmv      [NU][4];
  int unsigned lfsr;

  task automatic chk(input string req, input string what, input int idx,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s[%0d] actual %0d expected %0d", req, what, idx, act, exp);
    end
  endtask

  // compare every state slot against the reference model
  task automatic check_all(input int kexp, input string tag);
    longint mask;
    mask = (64'd1 << (1 << (kexp - 2))) - 1;
    chk("R7", {tag, " unit_active"}, kexp, longint'(unit_active), mask);
    for (int s = 0; s < NS; s++) begin
      chk("R3", {tag, " pm"}, s, longint'(pm_flat[s*PMW +: PMW]), ref_pm[s] % MODV);
      chk("R4", {tag, " dec"}, s, longint'(dec_vec[s]), longint'(ref_dec[s]));
      chk("R5", {tag, " diff"}, s, longint'(diff_flat[s*PMW +: PMW]), ref_diff[s]);
    end
  endtask

  task automatic load_ref_init();
    for (int s = 0; s < NS; s++) begin
      ref_pm[s]   = (s == 0) ? 0 : 512;
      ref_dec[s]  = 0;
      ref_diff[s] = 0;
    end
  endtask

  function automatic int next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr & 32'h3f);
  endfunction

  // pattern 0: pseudo-random, 1: all equal (ties), 2: extremes
  task automatic make_bms(input int pat, input int stage);
    for (int j = 0; j < NU; j++) begin
      for (int f = 0; f < 4; f++) begin
        case (pat)
          0:       bmv[j][f] = next_rand();
          1:       bmv[j][f] = 17;
          default: bmv[j][f] = (((j + f + stage) % 2) == 0) ? 63 : 0;
        endcase
        bm_flat[(4*j+f)*BMW +: BMW] = BMW'(bmv[j][f]);
      end
    end
  endtask

  // R1: butterfly model on integers, R6: states at or above 2^(K-1) untouched
  task automatic ref_step(input int kexp, input bit turbo);
    longint old_pm [NS];
    int     half;
    half = 1 << (kexp - 2);
    for (int s = 0; s < NS; s++) old_pm[s] = ref_pm[s];
    for (int s = 0; s < 2*half; s++) begin
      int j, hi;
      longint c0, c1;
      hi = (s >= half) ? 1 : 0;
      j  = hi ? s - half : s;
      c0 = old_pm[2*j]   + bmv[j][hi ? 2 : 0];
      c1 = old_pm[2*j+1] + bmv[j][hi ? 3 : 1];
      ref_pm[s]   = (c1 < c0) ? c1 : c0;
      ref_dec[s]  = (c1 < c0) ? 1 : 0;
      ref_diff[s] = turbo ? ((c0 > c1) ? c0 - c1 : c1 - c0) : 0;
    end
  endtask

  // one full run: start (optionally together with step), then stages
  task automatic run_cfg(input int kpin, input bit turbo, input int kexp,
                         input int pat, input int nsteps, input bit start_with_step);
    @(negedge clk);
    start     = 1'b1;
    cfg_k     = 4'(kpin);
    cfg_turbo = turbo;
    step      = start_with_step;
    make_bms(pat, 0);
    @(negedge clk);
    start = 1'b0;
    step  = 1'b0;
    // R10: scramble configuration pins after capture
    cfg_k     = (kexp == 3) ? 4'd7 : 4'd3;
    cfg_turbo = ~turbo;
    load_ref_init();
    chk("R2", "start out_valid", kexp, longint'(out_valid), 0);
    check_all(kexp, "R2 start");
    for (int t = 1; t <= nsteps; t++) begin
      if ((t % 7) == 0) begin
        step = 1'b0;
        @(negedge clk);
        chk("R9", "idle out_valid", t, longint'(out_valid), 0);
        check_all(kexp, "R9 idle");
      end
      make_bms(pat, t);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      ref_step(kexp, turbo);
      chk("R9", "out_valid", t, longint'(out_valid), 1);
      check_all(kexp, "R1 R10 stage");
    end
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    lfsr   = 32'h1234_5678;
    rst_n     = 1'b0;
    start     = 1'b0;
    cfg_k     = 4'd7;
    cfg_turbo = 1'b0;
    step      = 1'b0;
    bm_flat   = '0;
    #23;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    load_ref_init();
    chk("R9", "reset out_valid", 0, longint'(out_valid), 0);
    check_all(K_MAX, "R2 reset");

    for (int k = 3; k <= K_MAX; k++) begin
      run_cfg(k, 1'b1, k, 0, 300, 1'b0);
      run_cfg(k, 1'b0, k, 0, 60, 1'b0);
      run_cfg(k, 1'b1, k, 1, 10, 1'b0);
      run_cfg(k, 1'b1, k, 2, 20, 1'b0);
    end
    // R8: clamping of out-of-range lengths; R2: start beats step
    run_cfg(2, 1'b1, 3, 0, 20, 1'b1);
    run_cfg(0, 1'b0, 3, 0, 10, 1'b0);
    run_cfg(12, 1'b1, 7, 0, 20, 1'b1);
    run_cfg(8, 1'b1, 7, 2, 10, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule